// File: doc/BRIEF.md
# Two-dimensional strided copy engine

This block moves 32-bit words from one area of memory to another without processor involvement. Software describes a source rectangle and a destination rectangle. Each rectangle has a start byte address, a line length in words, a number of lines and a gap (stride) in words between the end of one line and the start of the next. Software then writes the control register to launch the read side and the write side. The two sides walk their own shapes, so the engine can reshape data: for example, four lines of six words can become three lines of eight words. Words reach the destination in the order they were read from the source.

The read side issues single-word requests on a read port with a grant and a later response strobe. It places each returned word in a 16-entry internal queue. The write side drains that queue through a write port with a request/grant handshake. A channel starts either on an external sync pulse or at once if its bypass bit is set. A status register shows which sides are still active.

Top module: `dma2d_engine`

## Requirements
- R1: After reset every register reads 0, and neither `rd_req` nor `wr_req` is asserted.
- R2: Configuration registers read back what was written. Offset 0x10 is the read start byte address, 0x14 the read line length, 0x18 the read line count and 0x1C the read stride. Offsets 0x20, 0x24, 0x28 and 0x2C hold the same four fields for the write side. All lengths and strides count 32-bit words.
- R3: In the control register at 0x00, bit 0 starts the write side, bit 1 starts the read side, bit 2 lets the write side skip the sync wait and bit 3 lets the read side skip it. A start bit clears itself in the cycle after the start is accepted, so writing 0x0F reads back 0x0C one cycle after the write.
- R4: A start bit with its skip bit clear stays pending and moves no data until that side's sync input (`sync_wr` or `sync_rd`) is high for a cycle.
- R5: Word k of line j lives at base + 4·(j·(length + stride) + k). A stride of 0 gives contiguous lines.
- R6: The n-th word written equals the n-th word read, whatever the two shapes are.
- R7: The status register at 0x04 has bit 0 set while the write side is active and bit 1 set while the read side is active. Each bit clears when its side has moved its last word, and status reads 0 once the transfer is finished.
- R8: The queue holds 16 words. The read side issues no request while the queue is full, and the write side issues no request while it is empty.
- R9: At most one read is outstanding: `rd_req` stays low from a grant until its response arrives.
- R10: Register writes made while a side is active do not change that side's transfer.
- R11: A start with a line length of 0 or a line count of 0 is accepted and clears its start bit, but moves no data and leaves status at 0.
- R12: A request that has not been granted holds its address, and on the write side its data, until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| sync_wr | input | 1 | Start trigger for the write side |
| sync_rd | input | 1 | Start trigger for the read side |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_gnt | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read response strobe |
| rd_rdata | input | 32 | Read response data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_gnt | input | 1 | Write request accepted |

## Verification
The bench reshapes six-by-four into eight-by-three with non-zero strides and checks the gap words around the destination lines. An engine that ignored the stride or used the wrong side's shape would move words or overwrite those gaps. It starts only the read side, so the queue fills and must stop reading at exactly 16 words. An off-by-one in the full test would show up as a 17th read or as a lost word. Further tests stall the grants and rewrite the configuration mid-transfer, where a design that did not capture its shape at start would jump addresses. They also hold off the sync input, launch zero-length starts, and copy a 1024-word block whose first words are known.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned OFF_W = 8;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_STAT   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_RBASE  = 8'h10;
  localparam logic [OFF_W-1:0] OFF_RLEN   = 8'h14;
  localparam logic [OFF_W-1:0] OFF_RLINES = 8'h18;
  localparam logic [OFF_W-1:0] OFF_RSTR   = 8'h1C;
  localparam logic [OFF_W-1:0] OFF_WBASE  = 8'h20;
  localparam logic [OFF_W-1:0] OFF_WLEN   = 8'h24;
  localparam logic [OFF_W-1:0] OFF_WLINES = 8'h28;
  localparam logic [OFF_W-1:0] OFF_WSTR   = 8'h2C;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] len;
    logic [REG_W-1:0] lines;
    logic [REG_W-1:0] stride;
  } shape_t;

  // start of the following line: skip the line itself plus the gap
  function automatic logic [REG_W-1:0] next_line_base(input logic [REG_W-1:0] base,
                                                      input logic [REG_W-1:0] len,
                                                      input logic [REG_W-1:0] stride);
    return base + ((len + stride) << 2);
  endfunction

  function automatic logic [REG_W-1:0] word_addr(input logic [REG_W-1:0] line_base,
                                                 input logic [REG_W-1:0] idx);
    return line_base + (idx << 2);
  endfunction
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFF_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic             busy_wr,
  input  logic             busy_rd,
  output shape_t           rd_shape,
  output shape_t           wr_shape,
  output logic             start_wr,
  output logic             start_rd,
  output logic             byp_wr,
  output logic             byp_rd
);
  logic [3:0] ctrl_q;
  shape_t     rd_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
    end else begin
      if (we && addr == OFF_CTRL) begin
        ctrl_q <= wdata[3:0];
      end else begin
        if (acc_wr) ctrl_q[0] <= 1'b0;
        if (acc_rd) ctrl_q[1] <= 1'b0;
      end
      if (we) begin
        case (addr)
          OFF_RBASE:  rd_q.base   <= wdata;
          OFF_RLEN:   rd_q.len    <= wdata;
          OFF_RLINES: rd_q.lines  <= wdata;
          OFF_RSTR:   rd_q.stride <= wdata;
          OFF_WBASE:  wr_q.base   <= wdata;
          OFF_WLEN:   wr_q.len    <= wdata;
          OFF_WLINES: wr_q.lines  <= wdata;
          OFF_WSTR:   wr_q.stride <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      OFF_CTRL:   rdata = {{(REG_W-4){1'b0}}, ctrl_q};
      OFF_STAT:   rdata = {{(REG_W-2){1'b0}}, busy_rd, busy_wr};
      OFF_RBASE:  rdata = rd_q.base;
      OFF_RLEN:   rdata = rd_q.len;
      OFF_RLINES: rdata = rd_q.lines;
      OFF_RSTR:   rdata = rd_q.stride;
      OFF_WBASE:  rdata = wr_q.base;
      OFF_WLEN:   rdata = wr_q.len;
      OFF_WLINES: rdata = wr_q.lines;
      OFF_WSTR:   rdata = wr_q.stride;
      default:    rdata = '0;
    endcase
  end

  assign rd_shape = rd_q;
  assign wr_shape = wr_q;
  assign start_wr = ctrl_q[0];
  assign start_rd = ctrl_q[1];
  assign byp_wr   = ctrl_q[2];
  assign byp_rd   = ctrl_q[3];
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  shape_t           shape,
  input  logic             step,
  output logic             busy,
  output logic [REG_W-1:0] addr
);
  logic [REG_W-1:0] len_q, lines_q, stride_q;
  logic [REG_W-1:0] line_base_q, word_q, line_q;
  logic             busy_q;
  logic             end_of_line, end_of_shape;

  assign end_of_line  = (word_q == len_q - 1'b1);
  assign end_of_shape = end_of_line && (line_q == lines_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q       <= '0;
      lines_q     <= '0;
      stride_q    <= '0;
      line_base_q <= '0;
      word_q      <= '0;
      line_q      <= '0;
      busy_q      <= 1'b0;
    end else if (start && !busy_q) begin
      // shape captured here; later register writes do not reach it
      len_q       <= shape.len;
      lines_q     <= shape.lines;
      stride_q    <= shape.stride;
      line_base_q <= shape.base;
      word_q      <= '0;
      line_q      <= '0;
      busy_q      <= (shape.len != '0) && (shape.lines != '0);
    end else if (step && busy_q) begin
      if (end_of_shape) begin
        busy_q <= 1'b0;
      end else if (end_of_line) begin
        word_q      <= '0;
        line_q      <= line_q + 1'b1;
        line_base_q <= next_line_base(line_base_q, len_q, stride_q);
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign addr = word_addr(line_base_q, word_q);
endmodule

// File: rtl/dma2d_fifo.sv
module dma2d_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wptr_q, rptr_q;
  logic         do_push, do_pop;

  assign full    = (wptr_q[PW] != rptr_q[PW]) && (wptr_q[PW-1:0] == rptr_q[PW-1:0]);
  assign empty   = (wptr_q == rptr_q);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q[PW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[PW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
  import dma2d_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFF_W-1:0] cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             sync_wr,
  input  logic             sync_rd,
  output logic             rd_req,
  output logic [REG_W-1:0] rd_addr,
  input  logic             rd_gnt,
  input  logic             rd_rvalid,
  input  logic [REG_W-1:0] rd_rdata,
  output logic             wr_req,
  output logic [REG_W-1:0] wr_addr,
  output logic [REG_W-1:0] wr_data,
  input  logic             wr_gnt
);
  shape_t rd_shape, wr_shape;
  logic   start_wr, start_rd, byp_wr, byp_rd;
  logic   acc_wr, acc_rd;
  logic   rd_busy, wr_busy;
  logic   rd_pend_q;
  logic   fifo_push, fifo_pop, fifo_full, fifo_empty;

  // named events for the checker
  assign acc_wr    = start_wr && !wr_busy && (byp_wr || sync_wr);
  assign acc_rd    = start_rd && !rd_busy && (byp_rd || sync_rd);
  assign fifo_push = rd_pend_q && rd_rvalid;
  assign fifo_pop  = wr_req && wr_gnt;

  dma2d_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .busy_wr  (wr_busy),
    .busy_rd  (rd_busy),
    .rd_shape (rd_shape),
    .wr_shape (wr_shape),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .byp_wr   (byp_wr),
    .byp_rd   (byp_rd)
  );

  dma2d_walker u_rd_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (acc_rd),
    .shape (rd_shape),
    .step  (fifo_push),
    .busy  (rd_busy),
    .addr  (rd_addr)
  );

  dma2d_walker u_wr_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (acc_wr),
    .shape (wr_shape),
    .step  (fifo_pop),
    .busy  (wr_busy),
    .addr  (wr_addr)
  );

  dma2d_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (rd_rdata),
    .pop   (fifo_pop),
    .dout  (wr_data),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  // one read in flight; a free slot is checked before issue
  assign rd_req = rd_busy && !rd_pend_q && !fifo_full;
  assign wr_req = wr_busy && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_pend_q <= 1'b0;
    else if (rd_req && rd_gnt) rd_pend_q <= 1'b1;
    else if (fifo_push)        rd_pend_q <= 1'b0;
  end
endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker
  import dma2d_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [OFF_W-1:0] cfg_addr,
  input logic             sync_wr,
  input logic             sync_rd,
  input logic             rd_req,
  input logic [REG_W-1:0] rd_addr,
  input logic             rd_gnt,
  input logic             rd_rvalid,
  input logic             wr_req,
  input logic [REG_W-1:0] wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic             wr_gnt,
  input logic             fifo_push,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             rd_pend_q,
  input logic             rd_busy,
  input logic             wr_busy,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic             start_rd,
  input logic             start_wr,
  input logic             byp_rd,
  input logic             byp_wr
);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);
  a_r8_no_read_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rd_req);
  a_r8_no_write_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !fifo_empty);
  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend_q |-> !rd_req);
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  a_r7_rd_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_busy) |-> $past(rd_rvalid));
  a_r7_wr_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> $past(wr_req && wr_gnt));
  a_r3_rd_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !(cfg_we && cfg_addr == OFF_CTRL) |=> !start_rd);
  a_r3_wr_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !(cfg_we && cfg_addr == OFF_CTRL) |=> !start_wr);
  a_r4_rd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |-> $past(byp_rd || sync_rd));
  a_r4_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(byp_wr || sync_wr));
endmodule

bind dma2d_engine dma2d_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .sync_wr    (sync_wr),
  .sync_rd    (sync_rd),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_gnt     (rd_gnt),
  .rd_rvalid  (rd_rvalid),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_gnt     (wr_gnt),
  .fifo_push  (fifo_push),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .rd_pend_q  (rd_pend_q),
  .rd_busy    (rd_busy),
  .wr_busy    (wr_busy),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .start_rd   (start_rd),
  .start_wr   (start_wr),
  .byp_rd     (byp_rd),
  .byp_wr     (byp_wr)
);

// File: tb/dma2d_engine_bench.sv
module dma2d_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sync_wr = 1'b0, sync_rd = 1'b0;
  logic        rd_req, wr_req;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        rd_gnt = 1'b0, rd_rvalid = 1'b0, wr_gnt = 1'b0;
  logic [31:0] rd_rdata = '0;

  always #5 clk = ~clk;

  dma2d_engine u_dma2d_engine (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [8192];
  int  rd_grants = 0, wr_grants = 0;
  bit  stall_en = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model: grants decided at the falling edge, response one cycle after grant
  initial begin
    bit          resp_due = 1'b0;
    logic [31:0] resp_addr = '0;
    int          cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_rvalid = resp_due;
      rd_rdata  = mem[resp_addr[14:2]];
      resp_due  = 1'b0;
      rd_gnt    = rd_req && (!stall_en || (cyc % 3 != 1));
      if (rd_gnt) begin
        resp_due  = 1'b1;
        resp_addr = rd_addr;
        rd_grants++;
      end
      wr_gnt = wr_req && (!stall_en || (cyc % 4 != 2));
      if (wr_gnt) begin
        mem[wr_addr[14:2]] = wr_data;
        wr_grants++;
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_shape(input bit rd_side, input logic [31:0] base, len, lines, stride);
    logic [7:0] o;
    o = rd_side ? 8'h10 : 8'h20;
    reg_write(o,        base);
    reg_write(o + 8'h4, len);
    reg_write(o + 8'h8, lines);
    reg_write(o + 8'hC, stride);
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'hDEADBEA7;
      1: return 32'hDEADC0DE;
      2: return 32'hCAFEBABE;
      3: return 32'h5555AAAA;
      default: return 32'h3C00_0000 ^ (k * 32'h0001_0013);
    endcase
  endfunction

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_read(8'h04, s);
      if (s == 0) begin
        chk(1'b1, tag, s, 0);
        return;
      end
    end
    chk(1'b0, {tag, " status never idle"}, s, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(8'h04, v); chk(v == 0, "R1 status after reset", v, 0);
    reg_read(8'h00, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    reg_read(8'h10, v); chk(v == 0, "R1 read base after reset", v, 0);
    chk(!rd_req && !wr_req, "R1 no requests after reset", {rd_req, wr_req}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] o;
      o = 8'h10 + 8'(i * 4);
      reg_write(o, 32'hA000_0000 + 32'(i * 32'h111));
    end
    for (int i = 0; i < 8; i++) begin
      logic [7:0] o;
      o = 8'h10 + 8'(i * 4);
      reg_read(o, v);
      if (v != 32'hA000_0000 + 32'(i * 32'h111)) ok = 1'b0;
    end
    chk(ok, "R2 config readback", v, 32'hA000_0777);
  endtask

  task automatic t_linear;
    logic [31:0] v;
    int bad = 0;
    for (int k = 0; k < 1024; k++) begin
      mem[(32'h1000 >> 2) + k] = pat(k);
      mem[(32'h3000 >> 2) + k] = 32'h0;
    end
    set_shape(1'b1, 32'h1000, 1024, 1, 0);
    set_shape(1'b0, 32'h3000, 1024, 1, 0);
    reg_write(8'h00, 32'h0F);
    reg_read(8'h00, v); chk(v == 32'h0C, "R3 start bits self-clear", v, 32'h0C);
    reg_read(8'h04, v); chk(v == 32'h3, "R7 both sides busy", v, 32'h3);
    wait_idle("R7 linear copy finishes");
    chk(mem[32'h3000 >> 2] == 32'hDEADBEA7, "R6 dst word0", mem[32'h3000 >> 2], 32'hDEADBEA7);
    chk(mem[(32'h3000 >> 2) + 1] == 32'hDEADC0DE, "R6 dst word1", mem[(32'h3000 >> 2) + 1], 32'hDEADC0DE);
    chk(mem[(32'h3000 >> 2) + 2] == 32'hCAFEBABE, "R6 dst word2", mem[(32'h3000 >> 2) + 2], 32'hCAFEBABE);
    chk(mem[(32'h3000 >> 2) + 3] == 32'h5555AAAA, "R6 dst word3", mem[(32'h3000 >> 2) + 3], 32'h5555AAAA);
    for (int k = 0; k < 1024; k++) if (mem[(32'h3000 >> 2) + k] != pat(k)) bad++;
    chk(bad == 0, "R5 all 1024 contiguous words", 32'(bad), 0);
  endtask

  task automatic t_reshape;
    int bad = 0;
    // source: 4 lines of 6, stride 2 (pitch 8); dest: 3 lines of 8, stride 4 (pitch 12)
    for (int i = 0; i < 64; i++) begin
      mem[(32'h5000 >> 2) + i] = 32'h5500_0000 + 32'(i);
      mem[(32'h6000 >> 2) + i] = 32'hEEEE_0000 + 32'(i);
    end
    set_shape(1'b1, 32'h5000, 6, 4, 2);
    set_shape(1'b0, 32'h6000, 8, 3, 4);
    reg_write(8'h00, 32'h0F);
    wait_idle("R7 reshape finishes");
    for (int i = 0; i < 40; i++) begin
      int line, col, k;
      logic [31:0] exp;
      line = i / 12; col = i % 12;
      if (col < 8 && line < 3) begin
        k = line * 8 + col;
        exp = 32'h5500_0000 + 32'((k / 6) * 8 + (k % 6));
      end else begin
        exp = 32'hEEEE_0000 + 32'(i);
      end
      if (mem[(32'h6000 >> 2) + i] != exp) bad++;
    end
    chk(bad == 0, "R5 R6 reshaped words and untouched gaps", 32'(bad), 0);
  endtask

  task automatic t_fifo_full;
    logic [31:0] v;
    int g0, bad = 0;
    for (int k = 0; k < 20; k++) mem[(32'h7000 >> 2) + k] = 32'h0;
    g0 = rd_grants;
    set_shape(1'b1, 32'h1000, 20, 1, 0);
    set_shape(1'b0, 32'h7000, 20, 1, 0);
    reg_write(8'h00, 32'h0A);
    repeat (200) @(negedge clk);
    chk(rd_grants - g0 == 16, "R8 reads stop at queue depth", 32'(rd_grants - g0), 16);
    chk(!rd_req, "R8 no read request while full", {31'b0, rd_req}, 0);
    reg_read(8'h04, v); chk(v == 32'h2, "R7 only read side busy", v, 32'h2);
    reg_write(8'h00, 32'h05);
    wait_idle("R7 drain finishes");
    for (int k = 0; k < 20; k++) if (mem[(32'h7000 >> 2) + k] != pat(k)) bad++;
    chk(bad == 0, "R8 no word lost across full queue", 32'(bad), 0);
  endtask

  task automatic t_stall_rewrite;
    logic [31:0] v;
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      mem[(32'h1000 >> 2) + k] = pat(k);
      mem[(32'h7400 >> 2) + k] = 32'h0;
    end
    stall_en = 1'b1;
    set_shape(1'b1, 32'h1000, 10, 3, 1);
    set_shape(1'b0, 32'h7400, 30, 1, 0);
    reg_write(8'h00, 32'h0F);
    repeat (10) @(negedge clk);
    reg_write(8'h10, 32'h2000);
    reg_write(8'h24, 32'd5);
    reg_read(8'h10, v); chk(v == 32'h2000, "R10 register shows new value", v, 32'h2000);
    wait_idle("R12 stalled copy finishes");
    stall_en = 1'b0;
    for (int k = 0; k < 30; k++) if (mem[(32'h7400 >> 2) + k] != pat((k / 10) * 11 + (k % 10))) bad++;
    chk(bad == 0, "R10 R12 transfer unaffected by rewrite under stalls", 32'(bad), 0);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    int g0, bad = 0;
    for (int k = 0; k < 4; k++) begin
      mem[(32'h1000 >> 2) + k] = pat(k);
      mem[(32'h7800 >> 2) + k] = 32'h0;
    end
    set_shape(1'b1, 32'h1000, 4, 1, 0);
    set_shape(1'b0, 32'h7800, 4, 1, 0);
    g0 = rd_grants;
    reg_write(8'h00, 32'h03);
    repeat (10) @(negedge clk);
    reg_read(8'h00, v); chk(v == 32'h3, "R4 start held pending", v, 32'h3);
    reg_read(8'h04, v); chk(v == 0, "R4 idle without sync", v, 0);
    chk(rd_grants == g0, "R4 no reads without sync", 32'(rd_grants - g0), 0);
    @(negedge clk); sync_rd = 1'b1; sync_wr = 1'b1;
    @(negedge clk); sync_rd = 1'b0; sync_wr = 1'b0;
    wait_idle("R4 synced copy finishes");
    reg_read(8'h00, v); chk(v == 0, "R4 R3 start bits cleared after sync", v, 0);
    for (int k = 0; k < 4; k++) if (mem[(32'h7800 >> 2) + k] != pat(k)) bad++;
    chk(bad == 0, "R4 synced data", 32'(bad), 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int g0, g1;
    g0 = rd_grants; g1 = wr_grants;
    set_shape(1'b1, 32'h1000, 0, 3, 0);
    set_shape(1'b0, 32'h7800, 4, 0, 0);
    reg_write(8'h00, 32'h0F);
    repeat (5) @(negedge clk);
    reg_read(8'h00, v); chk(v == 32'h0C, "R11 zero start accepted", v, 32'h0C);
    reg_read(8'h04, v); chk(v == 0, "R11 status stays idle", v, 0);
    chk(rd_grants == g0 && wr_grants == g1, "R11 nothing moved",
        32'(rd_grants - g0 + wr_grants - g1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regmap;
    t_linear;
    t_reshape;
    t_fifo_full;
    t_stall_rewrite;
    t_sync;
    t_zero;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule